// File: doc/BRIEF.md
# Four-Phase Integrator Rotation Sequencer

This block drives the control side of a charge-integrating front end built from four capacitor banks used in rotation. Each bank passes through four duties, one per bunch-crossing step: it integrates, it holds while its range comparators decide, it is read out through the phase multiplexers, and it is cleared. The four banks are staggered by one step each, so in every step one bank integrates and no charge is lost between crossings.

A phase step lasts `TICKS` clock cycles. The default is 4, so a 25 ns crossing needs a 160 MHz clock. Finer timing inside the step places the flash-converter clock pulse in the middle of the readout step and keeps comparator reset as a short strobe at the start of the clear step. For each step the block outputs one integrate strobe per bank, a capacitor-clear strobe, a comparator-clear strobe, a one-hot select for the analog phase multiplexer, the binary capacitor identifier, and the 2-bit range code of the bank being read. The range code is steered from the four bank inputs and registered at the same edge as the select, so downstream per-capacitor calibration always sees matching code and identifier. An output-valid flag stays low until the pipeline has filled.

The async active-low reset returns the rotation to bank 0 integrating. Reset release must already be synchronised to `clk` upstream.

Top module: `rot_sequencer`

## Requirements
- R1: In every cycle, reset included, exactly one bit of `integ_o` is high. During reset and the first step after release, that bit is bit 0.
- R2: A step lasts `TICKS` clock cycles. In step s after reset release (cycles s*TICKS to s*TICKS+TICKS-1), `integ_o` has only bit (s mod 4) set.
- R3: While bank k integrates, `rst_cap_o` has only bit ((k+1) mod 4) set, which is the bank that integrated three steps earlier, for the whole step. It never overlaps `integ_o`.
- R4: `rst_cmp_o` equals `rst_cap_o` in the first cycle of each step (tick 0) and is all zero in the other cycles.
- R5: While bank k integrates, `cap_id_o` is the binary value (k+2) mod 4, which is the bank integrated two steps earlier, and `mux_sel_o` is the one-hot code of that same bank (bit `cap_id_o` set).
- R6: `data_valid_o` is low during reset and steps 0 and 1 after release. It is high from step 2 onward until the next reset.
- R7: `exp_i` packs bank p's range code in bits [2p+1:2p]. At the edge that starts step s (s ≥ 2), `exp_o` takes the code of bank (s-2) mod 4 as presented in the last cycle of step s-1, and holds it for the whole step. While `data_valid_o` is low, `exp_o` is 0.
- R8: `flash_clk_o` is high at ticks TICKS/4 through TICKS-TICKS/4-1 of every step and low otherwise. This gives one centred pulse per step; with TICKS=4, ticks 1 and 2 are high.
- R9: Asserting `rst_n` low forces the outputs at once, without a clock, to: `integ_o`=0001, `rst_cap_o`=0010, `rst_cmp_o`=0010, `cap_id_o`=2, `mux_sel_o`=0100, `exp_o`=0, `data_valid_o`=0, `flash_clk_o`=0. This holds at any point in the rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock, TICKS cycles per bunch crossing |
| rst_n | input | 1 | Async active-low reset, release synchronised upstream |
| exp_i | input | 8 | Range codes of the four banks, bank p at [2p+1:2p] |
| integ_o | output | 4 | Per-bank integrate strobe |
| rst_cap_o | output | 4 | Per-bank capacitor clear strobe |
| rst_cmp_o | output | 4 | Per-bank comparator clear strobe (first tick) |
| mux_sel_o | output | 4 | One-hot analog phase multiplexer select |
| cap_id_o | output | 2 | Binary identifier of the bank being read |
| exp_o | output | 2 | Registered range code of the bank being read |
| data_valid_o | output | 1 | Readout outputs carry pipeline data |
| flash_clk_o | output | 1 | Flash converter clock, centred in the step |

## Verification
The assertions assume two things: reset is held low from time zero, and `rst_n` is deasserted only away from a clock edge. They make no assumption about `exp_i`; a new code may arrive in any cycle. The stimulus therefore changes `exp_i` in every cycle with a pseudo-random pattern, as well as using fixed and arithmetic patterns. This shows that only the value present in the last cycle before a step boundary reaches `exp_o`. A reset applied in mid-step checks that the rotation restarts from bank 0 whatever its prior position.

// File: rtl/rot_seq_pkg.sv
package rot_seq_pkg;
  localparam int NPH  = 4;
  localparam int PW   = $clog2(NPH);
  localparam int EXPW = 2;
  // offsets from the integrating bank, modulo NPH
  localparam int READ_LAG = 2;
  typedef logic [PW-1:0] phase_t;
  localparam phase_t READ_OFS = phase_t'(NPH - READ_LAG);
  localparam phase_t CLR_OFS  = phase_t'(1);
endpackage

// File: rtl/rot_step_timer.sv
module rot_step_timer #(
  parameter int TICKS = 4,
  localparam int TW = $clog2(TICKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [TW-1:0] tick_nx,
  output logic          step_adv
);
  logic [TW-1:0] tick_q;

  always_comb begin
    step_adv = (tick_q == TW'(TICKS - 1));
    tick_nx  = step_adv ? '0 : tick_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_nx;
  end

  // R2: step boundary is followed by tick 0 and then not another boundary
  p_step_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_adv |=> !step_adv);
endmodule

// File: rtl/rot_phase_ring.sv
module rot_phase_ring
  import rot_seq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_adv,
  output phase_t         phase_nx,
  output logic           valid_nx,
  output logic [NPH-1:0] integ_o,
  output logic [NPH-1:0] rst_cap_o,
  output logic [NPH-1:0] rst_cmp_o
);
  localparam int FW = $clog2(READ_LAG + 1);
  localparam logic [NPH-1:0] INTEG_RST = NPH'(1);
  localparam logic [NPH-1:0] CLR_RST   = NPH'(1) << CLR_OFS;

  phase_t          phase_q;
  phase_t          clr_nx;
  logic [FW-1:0]   fill_q, fill_nx;
  logic [NPH-1:0]  integ_nx, cap_nx, cmp_nx;

  always_comb begin
    phase_nx = step_adv ? phase_q + phase_t'(1) : phase_q;
    fill_nx  = fill_q;
    if (step_adv && fill_q != FW'(READ_LAG)) fill_nx = fill_q + FW'(1);
    valid_nx = (fill_nx == FW'(READ_LAG));
    clr_nx   = phase_nx + CLR_OFS;
  end

  for (genvar g = 0; g < NPH; g++) begin : g_bank
    always_comb begin
      integ_nx[g] = (phase_nx == phase_t'(g));
      cap_nx[g]   = (clr_nx == phase_t'(g));
      cmp_nx[g]   = cap_nx[g] & step_adv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= '0;
      fill_q    <= '0;
      integ_o   <= INTEG_RST;
      rst_cap_o <= CLR_RST;
      rst_cmp_o <= CLR_RST;
    end else begin
      phase_q   <= phase_nx;
      fill_q    <= fill_nx;
      integ_o   <= integ_nx;
      rst_cap_o <= cap_nx;
      rst_cmp_o <= cmp_nx;
    end
  end

  p_integ_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(integ_o) == 1);
  p_integ_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_adv |=> integ_o == {$past(integ_o[NPH-2:0]), $past(integ_o[NPH-1])});
  p_integ_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_adv |=> $stable(integ_o));
  p_clear_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_cap_o == {integ_o[NPH-2:0], integ_o[NPH-1]});
  p_clear_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cap_o & integ_o) == '0);
  p_cmp_within_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cmp_o & ~rst_cap_o) == '0);
endmodule

// File: rtl/rot_readout.sv
module rot_readout
  import rot_seq_pkg::*;
#(
  parameter int TICKS = 4,
  localparam int TW = $clog2(TICKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_adv,
  input  phase_t              phase_nx,
  input  logic                valid_nx,
  input  logic [TW-1:0]       tick_nx,
  input  logic [NPH*EXPW-1:0] exp_i,
  output logic [NPH-1:0]      mux_sel_o,
  output phase_t              cap_id_o,
  output logic [EXPW-1:0]     exp_o,
  output logic                data_valid_o,
  output logic                flash_clk_o
);
  localparam int FLASH_LO = TICKS / 4;
  localparam int FLASH_HI = TICKS - TICKS / 4;
  localparam logic [NPH-1:0] SEL_RST = NPH'(1) << READ_OFS;

  logic [EXPW-1:0] exp_arr [NPH];
  phase_t          read_nx;
  logic [NPH-1:0]  sel_nx;
  logic [EXPW-1:0] exp_nx;
  logic            flash_nx;

  for (genvar g = 0; g < NPH; g++) begin : g_lane
    assign exp_arr[g] = exp_i[g*EXPW +: EXPW];
    assign sel_nx[g]  = (read_nx == phase_t'(g));
  end

  always_comb begin
    read_nx  = phase_nx + READ_OFS;
    exp_nx   = valid_nx ? exp_arr[read_nx] : '0;
    flash_nx = (tick_nx >= TW'(FLASH_LO)) && (tick_nx < TW'(FLASH_HI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_sel_o    <= SEL_RST;
      cap_id_o     <= READ_OFS;
      data_valid_o <= 1'b0;
      flash_clk_o  <= 1'b0;
    end else begin
      mux_sel_o    <= sel_nx;
      cap_id_o     <= read_nx;
      data_valid_o <= valid_nx;
      flash_clk_o  <= flash_nx;
    end
  end

  // range code register: clock enable at step boundaries only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        exp_o <= '0;
    else if (step_adv) exp_o <= exp_nx;
  end

  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |=> data_valid_o);
  p_id_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_adv |=> cap_id_o == $past(cap_id_o) + phase_t'(1));
  p_sel_matches_id_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(mux_sel_o) && mux_sel_o[cap_id_o]);
  p_exp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_adv |=> $stable(exp_o));
  p_exp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid_o |-> exp_o == '0);
  p_flash_low_at_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_adv |=> !flash_clk_o);
endmodule

// File: rtl/rot_sequencer.sv
module rot_sequencer
  import rot_seq_pkg::*;
#(
  parameter int TICKS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPH*EXPW-1:0] exp_i,
  output logic [NPH-1:0]      integ_o,
  output logic [NPH-1:0]      rst_cap_o,
  output logic [NPH-1:0]      rst_cmp_o,
  output logic [NPH-1:0]      mux_sel_o,
  output logic [PW-1:0]       cap_id_o,
  output logic [EXPW-1:0]     exp_o,
  output logic                data_valid_o,
  output logic                flash_clk_o
);
  localparam int TW = $clog2(TICKS);

  logic [TW-1:0] tick_nx;
  logic          step_adv;
  phase_t        phase_nx;
  logic          valid_nx;

  rot_step_timer #(.TICKS(TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_nx  (tick_nx),
    .step_adv (step_adv)
  );

  rot_phase_ring u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_adv  (step_adv),
    .phase_nx  (phase_nx),
    .valid_nx  (valid_nx),
    .integ_o   (integ_o),
    .rst_cap_o (rst_cap_o),
    .rst_cmp_o (rst_cmp_o)
  );

  rot_readout #(.TICKS(TICKS)) u_read (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_adv     (step_adv),
    .phase_nx     (phase_nx),
    .valid_nx     (valid_nx),
    .tick_nx      (tick_nx),
    .exp_i        (exp_i),
    .mux_sel_o    (mux_sel_o),
    .cap_id_o     (cap_id_o),
    .exp_o        (exp_o),
    .data_valid_o (data_valid_o),
    .flash_clk_o  (flash_clk_o)
  );

  // R1, R9: integrate and clear never name the read bank
  p_read_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((integ_o | rst_cap_o) & mux_sel_o) == '0);
endmodule

// File: tb/rot_sequencer_tb.sv
module rot_sequencer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS = 4;

  typedef struct packed {
    logic [3:0] integ;
    logic [3:0] cap;
    logic [3:0] cmp;
    logic [3:0] sel;
    logic [1:0] id;
    logic [1:0] ex;
    logic       val;
    logic       fl;
  } obs_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] exp_i;
  logic [3:0] integ_o, rst_cap_o, rst_cmp_o, mux_sel_o;
  logic [1:0] cap_id_o, exp_o;
  logic       data_valid_o, flash_clk_o;

  obs_t        expq[$];
  int          vectors = 0;
  int          miscompares = 0;
  int unsigned cyc = 0;
  logic [1:0]  ex_model = 2'd0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_sequencer #(.TICKS(TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .exp_i(exp_i),
    .integ_o(integ_o), .rst_cap_o(rst_cap_o), .rst_cmp_o(rst_cmp_o),
    .mux_sel_o(mux_sel_o), .cap_id_o(cap_id_o), .exp_o(exp_o),
    .data_valid_o(data_valid_o), .flash_clk_o(flash_clk_o)
  );

  function automatic obs_t model(int unsigned cc, logic [1:0] ex);
    obs_t m;
    int unsigned s = cc / TICKS;
    int unsigned t = cc % TICKS;
    int unsigned k = s % 4;
    m.integ = 4'b0001 << k;
    m.cap   = 4'b0001 << ((k + 1) % 4);
    m.cmp   = (t == 0) ? m.cap : 4'b0000;
    m.id    = 2'((k + 2) % 4);
    m.sel   = 4'b0001 << m.id;
    m.val   = (s >= 2);
    m.ex    = m.val ? ex : 2'd0;
    m.fl    = (t >= TICKS/4) && (t < TICKS - TICKS/4);
    return m;
  endfunction

  function automatic obs_t observed();
    return '{integ_o, rst_cap_o, rst_cmp_o, mux_sel_o, cap_id_o, exp_o,
             data_valid_o, flash_clk_o};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(obs_t e);
    obs_t a = observed();
    chk("R1", "integ count", 32'($countones(a.integ)), 32'd1);
    chk("R2", "integ_o", 32'(a.integ), 32'(e.integ));
    chk("R3", "rst_cap_o", 32'(a.cap), 32'(e.cap));
    chk("R4", "rst_cmp_o", 32'(a.cmp), 32'(e.cmp));
    chk("R5", "cap_id_o", 32'(a.id), 32'(e.id));
    chk("R5", "mux_sel_o", 32'(a.sel), 32'(e.sel));
    chk("R6", "data_valid_o", 32'(a.val), 32'(e.val));
    chk("R7", "exp_o", 32'(a.ex), 32'(e.ex));
    chk("R8", "flash_clk_o", 32'(a.fl), 32'(e.fl));
  endtask

  // monitor: pops the expectation for each edge a quarter period after it
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (expq.size() > 0) compare_all(expq.pop_front());
    end
  end

  // driver: called at a negedge, returns at a negedge
  task automatic drive_cycles(int n, int mode);
    for (int i = 0; i < n; i++) begin
      int unsigned nxt;
      case (mode)
        0: exp_i = 8'hE4;
        1: begin
             lfsr  = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
             exp_i = lfsr[7:0];
           end
        default: exp_i = 8'(cyc * 37 + 11);
      endcase
      nxt = cyc + 1;
      if ((nxt % TICKS) == 0 && (nxt / TICKS) >= 2)
        ex_model = exp_i[2*(((nxt / TICKS) - 2) % 4) +: 2];
      expq.push_back(model(nxt, ex_model));
      cyc = nxt;
      @(negedge clk);
    end
  endtask

  // R9: asynchronous reset at the current negedge, checked before any edge
  task automatic apply_reset();
    rst_n = 1'b0;
    #1;
    chk("R9", "reset outputs", 32'(observed()), 32'(model(0, 2'd0)));
    chk("R1", "integ in reset", 32'(integ_o), 32'h1);
    @(negedge clk);
    chk("R9", "reset held", 32'(observed()), 32'(model(0, 2'd0)));
    @(negedge clk);
    rst_n = 1'b1;
    cyc   = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    miscompares++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    exp_i = 8'h00;
    @(negedge clk);
    apply_reset();
    drive_cycles(40, 0);   // fixed codes per bank
    drive_cycles(200, 1);  // new codes every cycle
    drive_cycles(7, 1);
    apply_reset();         // R9: mid-step reset restarts at bank 0
    drive_cycles(60, 2);
    drive_cycles(5, 0);
    apply_reset();         // R9: reset right after a step boundary
    drive_cycles(33, 1);
    @(posedge clk);
    #(CLK_PERIOD/2);
    finish_run();
  end
endmodule